// File: doc/BRIEF.md
# Latched 16-bit Interval Timer

This block is a down-counting interval timer with a 16-bit counter and a pair of byte-wide reload latches. A host reaches it through a byte bus with four addresses: the live counter (low and high byte) and the reload value (low and high byte). The counter drops by one on every system clock. When it passes zero, the block raises a time-out flag. The flag goes to an external interrupt controller, together with a strobe that marks every bus access that clears the flag.

A 2-bit mode value is captured from a load strobe. Bit 0 selects between a one-shot run and a free-running run. Bit 1 hands a waveform pin to the timer. In the one-shot pin mode the pin gives a single low pulse for each load. In the free-running pin mode it gives a square wave. Loading the counter high byte is the action that starts a timing run.

Top module: `lat_interval_timer`

## Requirements
- R1: The counter decreases by one on every clock edge that is neither a load nor an underflow. A read at address 0 returns the counter bits 7:0 and a read at address 1 returns bits 15:8, both combinationally.
- R2: A write to address 0 stores the data into the low reload latch only. The counter keeps counting undisturbed.
- R3: A write to address 1 does four things on the same edge: it stores the high reload latch, loads the counter with {data, low latch}, arms the timer and clears the time-out flag.
- R4: A read at address 0 clears the time-out flag on the next edge. If an underflow sets the flag on that same edge, the set takes precedence.
- R5: An underflow is an edge where the counter is 0 and no address-1 write occurs. In free-running modes (mode bit 0 = 1) every underflow reloads the counter from {high latch, low latch} and sets the flag, so the period is latch value + 1 cycles.
- R6: In one-shot modes (mode bit 0 = 0) an underflow wraps the counter to 16'hFFFF and counting goes on. Only the first underflow after an address-1 write sets the flag.
- R7: Addresses 2 and 3 read and write the low and high reload latches directly. They do not touch the counter or the flag.
- R8: In mode 2'b10 the pin goes low on the edge of an address-1 write and returns high on the first underflow after it. The result is one low pulse per load.
- R9: In mode 2'b11 the pin goes low on an address-1 write and inverts on every underflow.
- R10: In modes 2'b00 and 2'b01 the pin stays high. The clear strobe is high in any cycle that carries a read at address 0 or a write at address 1.
- R11: After reset the flag is 0, the mode is 2'b00, the pin is high, and the counter and both latches are 0.
- R12: The mode value is captured on an edge where the mode load strobe is high. Counting decisions on that edge still use the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter steps on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 counter low, 1 counter high, 2 latch low, 3 latch high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte |
| mode_ld | input | 1 | Captures mode_in |
| mode_in | input | 2 | Bit 0 free-running, bit 1 pin driven |
| tmo_flag | output | 1 | Time-out flag to the interrupt controller |
| tmo_clr | output | 1 | Marks an access that clears the flag |
| wave_out | output | 1 | Waveform pin, idles high |

## Verification
The hardest situations to reach are a flag-clearing read or a reloading high-byte write that falls on the exact edge where the counter sits at zero. There, set-versus-clear precedence and load-versus-underflow precedence decide the outcome. The stimulus reaches them with very short free-running periods (latch values of 2 and 3), issuing reads of the counter low byte on every cycle and high-byte writes at varying spacing, so that each phase of the period is met. A reference model runs alongside and is compared against the design on every clock.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int BYTE_W_DEF = 8;

  localparam logic [1:0] A_CNT_LO = 2'd0;
  localparam logic [1:0] A_CNT_HI = 2'd1;
  localparam logic [1:0] A_LAT_LO = 2'd2;
  localparam logic [1:0] A_LAT_HI = 2'd3;

  typedef enum logic [1:0] {
    M_ONESHOT = 2'b00,
    M_FREE    = 2'b01,
    M_PULSE   = 2'b10,
    M_SQUARE  = 2'b11
  } lt_mode_e;
endpackage

// File: rtl/lt_regif.sv
module lt_regif
  import lt_pkg::*;
#(
  parameter int BYTE_W = BYTE_W_DEF
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] cnt_lo,
  input  logic [BYTE_W-1:0] cnt_hi,
  input  logic [BYTE_W-1:0] lat_lo,
  input  logic [BYTE_W-1:0] lat_hi,
  output logic              ld_lo,
  output logic              ld_hi_lat,
  output logic              arm_wr,
  output logic              clr_acc,
  output logic [BYTE_W-1:0] rdata
);
  logic wr_acc, rd_acc, rd_lo;

  always_comb begin
    wr_acc    = sel & wr;
    rd_acc    = sel & ~wr;
    ld_lo     = wr_acc & ((addr == A_CNT_LO) | (addr == A_LAT_LO));
    ld_hi_lat = wr_acc & (addr == A_LAT_HI);
    arm_wr    = wr_acc & (addr == A_CNT_HI);
    rd_lo     = rd_acc & (addr == A_CNT_LO);
    clr_acc   = arm_wr | rd_lo;
  end

  always_comb begin
    unique case (addr)
      A_CNT_LO: rdata = cnt_lo;
      A_CNT_HI: rdata = cnt_hi;
      A_LAT_LO: rdata = lat_lo;
      default:  rdata = lat_hi;
    endcase
  end
endmodule

// File: rtl/lt_counter.sv
module lt_counter
  import lt_pkg::*;
#(
  parameter int BYTE_W = BYTE_W_DEF,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ld_lo,
  input  logic              ld_hi_lat,
  input  logic              arm_wr,
  input  logic              free_run,
  output logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] lat_lo,
  output logic [BYTE_W-1:0] lat_hi,
  output logic              uf,
  output logic              fire
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] lat_lo_q, lat_lo_d, lat_hi_q, lat_hi_d;
  logic              lat_lo_en, lat_hi_en;
  logic              armed_q, armed_d;

  always_comb begin
    uf        = ~arm_wr & (cnt_q == '0);
    fire      = uf & (free_run | armed_q);
    lat_lo_en = ld_lo;
    lat_lo_d  = wdata;
    lat_hi_en = ld_hi_lat | arm_wr;
    lat_hi_d  = wdata;
    if (arm_wr)
      cnt_d = {wdata, lat_lo_q};
    else if (uf)
      cnt_d = free_run ? {lat_hi_q, lat_lo_q} : '1;
    else
      cnt_d = cnt_q - CNT_ONE;
    if (arm_wr)
      armed_d = 1'b1;
    else if (uf & ~free_run)
      armed_d = 1'b0;
    else
      armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_lo_q <= '0;
      lat_hi_q <= '0;
    end else begin
      if (lat_lo_en) lat_lo_q <= lat_lo_d;
      if (lat_hi_en) lat_hi_q <= lat_hi_d;
    end
  end

  assign cnt    = cnt_q;
  assign lat_lo = lat_lo_q;
  assign lat_hi = lat_hi_q;
endmodule

// File: rtl/lt_flag_pin.sv
module lt_flag_pin
  import lt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ni,
  input  lt_mode_e mode,
  input  logic     fire,
  input  logic     arm_wr,
  input  logic     clr_acc,
  output logic     flag,
  output logic     pin
);
  logic flag_q, flag_d;
  logic pin_q, pin_d;

  always_comb begin
    if (fire)
      flag_d = 1'b1;
    else if (clr_acc)
      flag_d = 1'b0;
    else
      flag_d = flag_q;

    pin_d = pin_q;
    if (arm_wr & mode[1])
      pin_d = 1'b0;
    else if (fire & (mode == M_PULSE))
      pin_d = 1'b1;
    else if (fire & (mode == M_SQUARE))
      pin_d = ~pin_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      pin_q  <= 1'b1;
    end else begin
      flag_q <= flag_d;
      pin_q  <= pin_d;
    end
  end

  assign flag = flag_q;
  assign pin  = mode[1] ? pin_q : 1'b1;
endmodule

// File: rtl/lat_interval_timer.sv
module lat_interval_timer
  import lt_pkg::*;
#(
  parameter int BYTE_W = BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              mode_ld,
  input  logic [1:0]        mode_in,
  output logic              tmo_flag,
  output logic              tmo_clr,
  output logic              wave_out
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  lt_mode_e          mode_q, mode_d;
  logic              mode_en;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] lat_lo, lat_hi;
  logic              ld_lo, ld_hi_lat, arm_wr, clr_acc, uf, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  always_comb begin
    mode_en = mode_ld;
    mode_d  = lt_mode_e'(mode_in);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mode_q <= M_ONESHOT;
    else if (mode_en) mode_q <= mode_d;
  end

  lt_regif #(.BYTE_W(BYTE_W)) u_regif (
    .sel       (bus_sel),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .cnt_lo    (cnt[BYTE_W-1:0]),
    .cnt_hi    (cnt[CNT_W-1:BYTE_W]),
    .lat_lo    (lat_lo),
    .lat_hi    (lat_hi),
    .ld_lo     (ld_lo),
    .ld_hi_lat (ld_hi_lat),
    .arm_wr    (arm_wr),
    .clr_acc   (clr_acc),
    .rdata     (bus_rdata)
  );

  lt_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .wdata     (bus_wdata),
    .ld_lo     (ld_lo),
    .ld_hi_lat (ld_hi_lat),
    .arm_wr    (arm_wr),
    .free_run  (mode_q[0]),
    .cnt       (cnt),
    .lat_lo    (lat_lo),
    .lat_hi    (lat_hi),
    .uf        (uf),
    .fire      (fire)
  );

  lt_flag_pin u_fp (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .mode    (mode_q),
    .fire    (fire),
    .arm_wr  (arm_wr),
    .clr_acc (clr_acc),
    .flag    (tmo_flag),
    .pin     (wave_out)
  );

  assign tmo_clr = clr_acc;

  logic unused_uf;
  assign unused_uf = uf;
endmodule

// File: rtl/lt_checker.sv
module lt_checker #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              sel,
  input logic              wr,
  input logic [1:0]        addr,
  input logic [BYTE_W-1:0] wdata,
  input logic              mode_ld,
  input logic [1:0]        mode,
  input logic [CNT_W-1:0]  cnt,
  input logic [BYTE_W-1:0] lat_lo,
  input logic [BYTE_W-1:0] lat_hi,
  input logic              flag,
  input logic              wave
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic hi_wr, rd_lo, at_zero, armed_seen;
  assign hi_wr   = sel & wr & (addr == 2'd1);
  assign rd_lo   = sel & ~wr & (addr == 2'd0);
  assign at_zero = (cnt == '0);

  // Tracks whether a one-shot run is still pending, from port activity only.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) armed_seen <= 1'b0;
    else if (hi_wr) armed_seen <= 1'b1;
    else if (at_zero & ~mode[0]) armed_seen <= 1'b0;
  end

  p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (!hi_wr && !at_zero) |=> (cnt == $past(cnt) - ONE));

  p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    hi_wr |=> (cnt == {$past(wdata), $past(lat_lo)}));

  p_load_clears_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    hi_wr |=> !flag);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_lo && !(at_zero && (mode[0] || armed_seen))) |=> !flag);

  p_free_reload_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!hi_wr && at_zero && mode[0]) |=> (flag && cnt == {$past(lat_hi), $past(lat_lo)}));

  p_oneshot_once_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!hi_wr && !armed_seen && !mode[0] && !flag) |=> !flag);

  p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (hi_wr && mode[1] && !mode_ld) |=> !wave);

  p_square_flip_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 2'b11 && !mode_ld && !hi_wr && at_zero) |=> (wave != $past(wave)));

  p_pin_idle_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !mode[1] |-> wave);
endmodule

bind lat_interval_timer lt_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk     (clk),
  .rst_ni  (rst_sync_n),
  .sel     (bus_sel),
  .wr      (bus_wr),
  .addr    (bus_addr),
  .wdata   (bus_wdata),
  .mode_ld (mode_ld),
  .mode    (mode_q),
  .cnt     (cnt),
  .lat_lo  (lat_lo),
  .lat_hi  (lat_hi),
  .flag    (tmo_flag),
  .wave    (wave_out)
);

// File: tb/sim_lat_interval_timer.sv
`timescale 1ns/1ps
module sim_lat_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, mode_ld = 1'b0;
  logic [1:0] bus_addr = 2'd0, mode_in = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tmo_flag, tmo_clr, wave_out;

  int    n_chk = 0, n_fail = 0, cyc = 0, rel = 0;
  string tag = "R11";
  bit    done = 0;

  // reference model state
  logic [15:0] m_cnt;
  logic [7:0]  m_llo, m_lhi;
  logic [1:0]  m_mode;
  logic        m_arm, m_flag, m_pin;

  always #5 clk = ~clk;

  lat_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode_ld(mode_ld), .mode_in(mode_in), .tmo_flag(tmo_flag),
    .tmo_clr(tmo_clr), .wave_out(wave_out)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0;
      m_cnt = 16'h0; m_llo = 8'h0; m_lhi = 8'h0; m_mode = 2'b00;
      m_arm = 1'b0; m_flag = 1'b0; m_pin = 1'b1;
    end else if (rel < 2) begin
      rel = rel + 1;
    end else begin
      logic hw, lw, lhw, rd0, uf, fire;
      logic [15:0] n_cnt;
      hw   = bus_sel & bus_wr & (bus_addr == 2'd1);
      lw   = bus_sel & bus_wr & (bus_addr == 2'd0 || bus_addr == 2'd2);
      lhw  = bus_sel & bus_wr & (bus_addr == 2'd3);
      rd0  = bus_sel & !bus_wr & (bus_addr == 2'd0);
      uf   = !hw && (m_cnt == 16'h0);
      fire = uf && (m_mode[0] || m_arm);
      if (hw) n_cnt = {bus_wdata, m_llo};
      else if (uf) n_cnt = m_mode[0] ? {m_lhi, m_llo} : 16'hFFFF;
      else n_cnt = m_cnt - 16'd1;
      if (fire) m_flag = 1'b1;
      else if (hw || rd0) m_flag = 1'b0;
      if (hw && m_mode[1]) m_pin = 1'b0;
      else if (fire && m_mode == 2'b10) m_pin = 1'b1;
      else if (fire && m_mode == 2'b11) m_pin = !m_pin;
      if (hw) m_arm = 1'b1;
      else if (uf && !m_mode[0]) m_arm = 1'b0;
      m_cnt = n_cnt;
      if (lw) m_llo = bus_wdata;
      if (lhw || hw) m_lhi = bus_wdata;
      if (mode_ld) m_mode = mode_in;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    logic exp_clr;
    logic [7:0] exp_rd;
    cyc++;
    if (!done) begin
      exp_clr = bus_sel & ((!bus_wr & bus_addr == 2'd0) | (bus_wr & bus_addr == 2'd1));
      chk("flag", int'(tmo_flag), int'(m_flag));
      chk("wave", int'(wave_out), int'(m_mode[1] ? m_pin : 1'b1));
      chk("clear strobe", int'(tmo_clr), int'(exp_clr));
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          2'd0: exp_rd = m_cnt[7:0];
          2'd1: exp_rd = m_cnt[15:8];
          2'd2: exp_rd = m_llo;
          default: exp_rd = m_lhi;
        endcase
        chk("read data", int'(bus_rdata), int'(exp_rd));
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0; mode_ld = 1'b0;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    mode_ld = 1'b0; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [1:0] a);
    @(posedge clk); #1;
    mode_ld = 1'b0; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; mode_ld = 1'b1; mode_in = m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tag = "R11";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3);
    rd(2'd2); rd(2'd3); idle(2);
    // R1: free counting from reset value, read both bytes
    tag = "R1";
    rd(2'd0); rd(2'd1); rd(2'd0); idle(4);
    // R2: low latch write leaves the counter running
    tag = "R2";
    wr(2'd0, 8'h05); rd(2'd0); rd(2'd2); rd(2'd1); idle(1);
    // R3: high write loads, arms, clears
    tag = "R3";
    wr(2'd1, 8'h00); rd(2'd0); idle(8);
    // R4: clearing read
    tag = "R4";
    rd(2'd0); idle(3);
    // R6: one-shot wraps and stays quiet
    tag = "R6";
    rd(2'd1); idle(40); rd(2'd0); rd(2'd1);
    wr(2'd0, 8'h00); wr(2'd1, 8'h01); idle(300); rd(2'd0); idle(20);
    // R7: direct latch access
    tag = "R7";
    wr(2'd2, 8'h10); wr(2'd3, 8'h00); rd(2'd2); rd(2'd3); rd(2'd0); idle(2);
    // R12: mode switch to free-running
    tag = "R12";
    set_mode(2'b01); wr(2'd1, 8'h00); idle(5);
    // R5: free-running period latch+1, reads at varying phase
    tag = "R5";
    idle(40); rd(2'd0); idle(7); rd(2'd0); idle(11);
    wr(2'd2, 8'h03); wr(2'd3, 8'h00); idle(6);
    tag = "R4";
    for (int i = 0; i < 12; i++) rd(2'd0);
    idle(5);
    // R8: single low pulse per load
    tag = "R8";
    set_mode(2'b10); wr(2'd0, 8'h08); wr(2'd1, 8'h00); idle(30);
    wr(2'd1, 8'h00); idle(4); wr(2'd1, 8'h00); idle(20);
    // R9: square wave, and loads at varying phase
    tag = "R9";
    set_mode(2'b11); wr(2'd0, 8'h02); wr(2'd1, 8'h00); idle(25);
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, 8'h00); idle(i);
    end
    idle(10);
    // R10: pin modes released, pin idles high
    tag = "R10";
    set_mode(2'b01); idle(10); set_mode(2'b00); wr(2'd1, 8'h00); idle(10);
    // R12: mode change on an underflow edge
    tag = "R12";
    set_mode(2'b11); wr(2'd0, 8'h02); wr(2'd1, 8'h00); idle(2);
    set_mode(2'b01); idle(6); set_mode(2'b10); idle(6);
    idle(5);
    finish_run();
  end
endmodule